// File: doc/BRIEF.md
# Three-Level Page Table Walker

This unit turns a 64-bit virtual address into a 56-bit physical address by walking a three-level page table in a memory of 64-bit words. A requester presents an address together with the current privilege mode and the translation control register. If translation is enabled, the unit fetches one table entry per level through a simple read port. It starts at the top level and stops at the first leaf entry. It then returns the physical address, the size of the page it reached, a one-cycle done pulse and a fault flag.

When translation is disabled, the unit returns the virtual address unchanged and reads no memory. A leaf at the top level maps a 1 GiB page and a leaf at the middle level maps a 2 MiB page. In both cases the lower virtual page number fields pass straight into the physical address. A leaf at the bottom level maps a 4 KiB page.

Top module: `ptw_walk_top`

## Requirements
- R1: Translation is off when bit 63 of `satp_i` is 0, or when `priv_mode_i` is 2'b11 (machine mode). In that case `done_o` rises in the cycle after acceptance with `pa_o` equal to bits 55:0 of the virtual address, `page_size_o` = 0, `fault_o` = 0, and `mem_req_o` stays low.
- R2: The first read of a walk uses word address {`satp_i[43:0]`, VA[38:30]}, which is the root base plus 8 times the top index, divided by 8.
- R3: A non-leaf entry (bits 1 and 3 both 0) makes the next read go to word address {PTE[53:10], next index}. The index is VA[29:21] at the middle level and VA[20:12] at the bottom level, and the levels are visited top, middle, bottom.
- R4: An entry with bit 1 (read) or bit 3 (execute) set is a leaf. A leaf at the top level ends the walk with `page_size_o` = 2 and `pa_o` = {PTE[53:28], VA[29:12], VA[11:0]}.
- R5: A leaf at the middle level gives `page_size_o` = 1 and `pa_o` = {PTE[53:19], VA[20:12], VA[11:0]}.
- R6: A leaf at the bottom level gives `page_size_o` = 0 and `pa_o` = {PTE[53:10], VA[11:0]}.
- R7: An entry with bit 0 (valid) clear ends the walk with `fault_o` = 1, `pa_o` = 0 and `page_size_o` = 0.
- R8: An entry with bit 2 (write) set and bit 1 clear ends the walk as a fault, with the same outputs as R7.
- R9: A non-leaf valid entry read at the bottom level ends the walk as a fault.
- R10: Exactly one read pulse of one cycle is issued per level, so a walk makes at most three reads. The unit waits any number of cycles for `mem_rvalid_i`, and `done_o` rises in the cycle after the `mem_rvalid_i` of the final entry.
- R11: `req_ready_o` is high only when the unit is idle. While a walk is in progress, `req_valid_i` and all request inputs are ignored. `done_o` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Unit idle, request accepted this cycle if valid |
| req_vaddr_i | input | 64 | Virtual address |
| priv_mode_i | input | 2 | Current privilege mode, 2'b11 = machine |
| satp_i | input | 64 | Translation control: bit 63 enable, bits 43:0 root page number |
| mem_req_o | output | 1 | Read pulse for one table entry |
| mem_addr_o | output | 53 | Word index of the entry |
| mem_rdata_i | input | 64 | Entry data |
| mem_rvalid_i | input | 1 | Entry data valid, at least one cycle after the read pulse |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Walk ended on an invalid or reserved entry |
| pa_o | output | 56 | Physical address |
| page_size_o | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |

## Verification
A bypass result is due at the first clock after acceptance. A walk result is due exactly one clock after the response valid of its last entry. Each read pulse is due one clock after acceptance or after the previous entry's response. The bench drives and samples on the falling edge. It tracks the cycle of the last response it returned, and it checks that `done_o` appears in the cycle that follows and never earlier or later. The memory latency is random from 1 to 4 cycles, and request inputs are scrambled during every walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 64;
  localparam int PA_W   = 56;
  localparam int PO_W   = 12;
  localparam int VPN_W  = 9;
  localparam int LEVELS = 3;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int PPN_W  = PA_W - PO_W;
  localparam int WADR_W = PPN_W + VPN_W;
  localparam int PTE_W  = 64;
  localparam int BIT_V  = 0;
  localparam int BIT_R  = 1;
  localparam int BIT_W  = 2;
  localparam int BIT_X  = 3;
  localparam int PPN_LSB = 10;
  localparam int SATP_EN = 63;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} walk_state_e;
endpackage

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             leaf_o,
  output logic             fault_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic valid, reserved;

  always_comb begin
    valid    = pte_i[BIT_V];
    reserved = pte_i[BIT_W] & ~pte_i[BIT_R];
    leaf_o   = pte_i[BIT_R] | pte_i[BIT_X];
    fault_o  = ~valid | reserved | (~leaf_o && lvl_i == '0);
    ppn_o    = pte_i[PPN_LSB +: PPN_W];
  end
endmodule

// File: rtl/ptw_pa_form.sv
module ptw_pa_form
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  va_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [PA_W-1:0]  pa_o
);
  logic [PA_W-1:0] cand [LEVELS];

  // higher levels pass more virtual index bits through
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int KEEP = PO_W + VPN_W * l;
    assign cand[l] = {ppn_i[PPN_W-1:VPN_W*l], va_i[KEEP-1:0]};
  end

  always_comb begin
    pa_o = cand[0];
    for (int l = 1; l < LEVELS; l++)
      if (lvl_i == LVL_W'(l)) pa_o = cand[l];
  end
endmodule

// File: rtl/ptw_walk_top.sv
module ptw_walk_top
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [63:0]       req_vaddr_i,
  input  logic [1:0]        priv_mode_i,
  input  logic [63:0]       satp_i,
  output logic              mem_req_o,
  output logic [52:0]       mem_addr_o,
  input  logic [63:0]       mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [55:0]       pa_o,
  output logic [1:0]        page_size_o
);
  walk_state_e      state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PPN_W-1:0] ppn_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  pa_q;
  logic [1:0]       size_q;
  logic             fault_q;

  logic             xlate;
  logic             pte_leaf, pte_fault;
  logic [PPN_W-1:0] pte_ppn;
  logic [PA_W-1:0]  leaf_pa;
  logic [VPN_W-1:0] vpn_f [LEVELS];
  logic [VPN_W-1:0] vpn_cur;

  for (genvar l = 0; l < LEVELS; l++) begin : g_vpn
    assign vpn_f[l] = va_q[PO_W + VPN_W*l +: VPN_W];
  end

  always_comb begin
    vpn_cur = vpn_f[0];
    for (int l = 1; l < LEVELS; l++)
      if (lvl_q == LVL_W'(l)) vpn_cur = vpn_f[l];
  end

  assign xlate = satp_i[SATP_EN] && (priv_mode_i != PRIV_MACHINE);

  ptw_pte_eval u_eval (
    .pte_i   (mem_rdata_i),
    .lvl_i   (lvl_q),
    .leaf_o  (pte_leaf),
    .fault_o (pte_fault),
    .ppn_o   (pte_ppn)
  );

  ptw_pa_form u_pa (
    .va_i  (va_q),
    .ppn_i (pte_ppn),
    .lvl_i (lvl_q),
    .pa_o  (leaf_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      ppn_q   <= '0;
      va_q    <= '0;
      pa_q    <= '0;
      size_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q <= req_vaddr_i;
          if (xlate) begin
            ppn_q   <= satp_i[PPN_W-1:0];
            lvl_q   <= LVL_W'(LEVELS - 1);
            state_q <= ST_ISSUE;
          end else begin
            pa_q    <= req_vaddr_i[PA_W-1:0];
            size_q  <= '0;
            fault_q <= 1'b0;
            state_q <= ST_DONE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          if (pte_fault) begin
            pa_q    <= '0;
            size_q  <= '0;
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else if (pte_leaf) begin
            pa_q    <= leaf_pa;
            size_q  <= 2'(lvl_q);
            fault_q <= 1'b0;
            state_q <= ST_DONE;
          end else begin
            ppn_q   <= pte_ppn;
            lvl_q   <= lvl_q - 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_ISSUE);
  assign mem_addr_o  = {ppn_q, vpn_cur};
  assign done_o      = (state_q == ST_DONE);
  assign fault_o     = fault_q;
  assign pa_o        = pa_q;
  assign page_size_o = size_q;
endmodule

// File: rtl/ptw_walk_chk.sv
module ptw_walk_chk
  import ptw_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [63:0] req_vaddr_i,
  input logic [1:0]  priv_mode_i,
  input logic [63:0] satp_i,
  input logic        mem_req_o,
  input logic        done_o,
  input logic        fault_o,
  input logic [55:0] pa_o,
  input logic [1:0]  page_size_o
);
  logic [2:0] reads_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reads_q <= '0;
    else if (req_valid_i && req_ready_o) reads_q <= '0;
    else if (mem_req_o) reads_q <= reads_q + 1'b1;
  end

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_no_read_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r10_max_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> reads_q < 3'(LEVELS));

  a_r1_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (!satp_i[SATP_EN] || priv_mode_i == PRIV_MACHINE))
    |=> (done_o && !fault_o && page_size_o == 2'd0 && pa_o == $past(req_vaddr_i[55:0])));

  a_r7_fault_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (pa_o == '0 && page_size_o == 2'd0));
endmodule

bind ptw_walk_top ptw_walk_chk u_chk (.*);

// File: tb/ptw_walk_top_tb_top.sv
`timescale 1ns/1ps
module ptw_walk_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [63:0] req_vaddr_i = '0;
  logic [1:0]  priv_mode_i = '0;
  logic [63:0] satp_i = '0;
  logic        mem_req_o;
  logic [52:0] mem_addr_o;
  logic [63:0] mem_rdata_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic        done_o, fault_o;
  logic [55:0] pa_o;
  logic [1:0]  page_size_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [52:0] exp_addr [3];
  logic [63:0] mem_data [3];
  int          exp_n;
  logic [55:0] exp_pa;
  logic [1:0]  exp_size;
  logic        exp_fault;

  always #4 clk_i = ~clk_i;

  ptw_walk_top dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [55:0] leaf_pa(input logic [63:0] va, input logic [63:0] pte, input int lvl);
    case (lvl)
      2: return {pte[53:28], va[29:21], va[20:12], va[11:0]};
      1: return {pte[53:19], va[20:12], va[11:0]};
      default: return {pte[53:10], va[11:0]};
    endcase
  endfunction

  // fk: 0 leaf, 1 invalid, 2 write-without-read, 3 pointer at bottom
  task automatic build(input logic [63:0] va, input logic [43:0] root, input int stop, input int fk);
    logic [43:0] cur;
    logic [63:0] pte;
    cur = root; exp_n = 0;
    for (int l = 2; l >= 0; l--) begin
      exp_addr[exp_n] = {cur, va[12 + 9*l +: 9]};
      if (l == stop) begin
        pte = rnd64();
        exp_fault = 1'b1; exp_pa = '0; exp_size = 2'd0;
        if (fk == 1) pte[0] = 1'b0;
        else if (fk == 2) begin pte[0] = 1'b1; pte[1] = 1'b0; pte[2] = 1'b1; end
        else if (fk == 3) begin pte[0] = 1'b1; pte[1] = 1'b0; pte[2] = 1'b0; pte[3] = 1'b0; end
        else begin
          pte[0] = 1'b1;
          if (pte[2]) pte[1] = 1'b1;
          if (!pte[1] && !pte[3]) pte[3] = 1'b1;
          exp_fault = 1'b0; exp_pa = leaf_pa(va, pte, l); exp_size = 2'(l);
        end
        mem_data[exp_n] = pte; exp_n++;
        break;
      end else begin
        pte = rnd64();
        pte[3:0] = 4'b0001;
        mem_data[exp_n] = pte;
        cur = pte[53:10];
        exp_n++;
      end
    end
  endtask

  task automatic run(input logic [63:0] va, input logic [63:0] satp, input logic [1:0] priv,
                     input int lat, input string tag);
    int cnt, n, got;
    bit prev_rv;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R11 ready when idle", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1; req_vaddr_i = va; satp_i = satp; priv_mode_i = priv;
    cnt = 0; n = 0; got = 0; prev_rv = 0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk_i);
      mem_rvalid_i = 1'b0;
      mem_rdata_i = rnd64();
      if (done_o) begin
        chk(pa_o == exp_pa, {tag, " pa"}, 64'(pa_o), 64'(exp_pa));
        chk(page_size_o == exp_size, {tag, " page size"}, 64'(page_size_o), 64'(exp_size));
        chk(fault_o == exp_fault, {tag, " fault"}, 64'(fault_o), 64'(exp_fault));
        chk(n == exp_n, "R10 read count", 64'(n), 64'(exp_n));
        if (exp_n == 0) chk(cyc == 0, "R1 bypass latency", 64'(cyc), 64'd0);
        else chk(prev_rv, "R10 done one cycle after last response", 64'(prev_rv), 64'd1);
        req_valid_i = 1'b0;
        got = 1;
        break;
      end
      if (mem_req_o) begin
        if (n < exp_n)
          chk(mem_addr_o == exp_addr[n], (n == 0) ? "R2 root read address" : "R3 next level address",
              64'(mem_addr_o), 64'(exp_addr[n]));
        else chk(1'b0, "R10 extra read", 64'(n), 64'(exp_n));
        cnt = lat; n++;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i = mem_data[(n > 0) ? n - 1 : 0];
        end
      end
      prev_rv = mem_rvalid_i;
      // R11: busy unit must ignore these
      req_valid_i = 1'b1; req_vaddr_i = rnd64(); satp_i = rnd64(); priv_mode_i = 2'($urandom());
    end
    if (!got) chk(1'b0, "R10 no done", 64'd0, 64'd1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R11 done single cycle", 64'(done_o), 64'd0);
    mem_rvalid_i = 1'b0;
  endtask

  task automatic walk(input int stop, input int fk, input int lat, input string tag);
    logic [63:0] va, satp;
    va = rnd64(); satp = rnd64(); satp[63] = 1'b1;
    build(va, satp[43:0], stop, fk);
    run(va, satp, 2'($urandom_range(0, 1)), lat, tag);
  endtask

  task automatic bypass(input logic [63:0] satp, input logic [1:0] priv);
    logic [63:0] va;
    va = rnd64();
    exp_n = 0; exp_pa = va[55:0]; exp_size = 2'd0; exp_fault = 1'b0;
    run(va, satp, priv, 1, "R1 bypass");
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    #20;
    chk(done_o == 1'b0 && req_ready_o == 1'b1 && mem_req_o == 1'b0, "R11 reset state",
        {61'd0, done_o, req_ready_o, mem_req_o}, 64'd2);
    rst_ni = 1'b1;
    // directed
    bypass(64'h0, 2'b00);
    bypass(64'h8000_0000_0000_0000 | rnd64(), 2'b11);
    walk(2, 0, 1, "R4 gigapage");
    walk(1, 0, 3, "R5 megapage");
    walk(0, 0, 4, "R6 small page");
    walk(2, 1, 2, "R7 invalid entry");
    walk(0, 1, 1, "R7 invalid entry");
    walk(1, 2, 1, "R8 write without read");
    walk(0, 3, 2, "R9 pointer at bottom");
    // random mix
    for (int i = 0; i < 300; i++) begin
      int k, stop, fk;
      k = $urandom_range(0, 9);
      if (k == 0) bypass({1'b0, rnd64()[62:0]}, 2'($urandom()));
      else if (k == 1) bypass({1'b1, rnd64()[62:0]}, 2'b11);
      else begin
        stop = $urandom_range(0, 2);
        fk = $urandom_range(0, 3);
        if (fk == 3) stop = 0;
        walk(stop, fk, $urandom_range(1, 4),
             (fk == 1) ? "R7 random" : (fk == 2) ? "R8 random" : (fk == 3) ? "R9 random" :
             (stop == 2) ? "R4 random" : (stop == 1) ? "R5 random" : "R6 random");
      end
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule